// File: doc/BRIEF.md
# I2C Target Address Matcher with Latched Selection Pins

This block watches the start of every I2C transaction on an oversampled bus and decides whether the target device should respond. The 7-bit target address has two parts. The upper four bits are a fixed device code. The lower three bits come from two board-level selection inputs. Each selection input is already digitised into one of three levels: low, high or floating.

The selection inputs are not followed continuously. They are captured once after reset. After that they are captured again only when a general-call reset or general-call latch command is received. Between those events the captured value is held, whatever the inputs do.

When an address byte ends, the block reports whether it matched and which direction was requested. For its own address or a general call, it pulls SDA low during the ninth clock. For anything else it stays silent until the next START. A general call followed by a recognised command byte produces a one-cycle pulse and reloads the captured address.

Top module: `i2c_addr_latch_match`

## Requirements
- R1: While reset is applied, `sda_pull_o`, `addr_match`, `rw_dir`, `gc_reset_pulse` and `gc_latch_pulse` are 0. After release, `latched_addr` holds the decoded selection inputs within SEL_SYNC_STAGES+1 clocks.
- R2: Selection codes are 2'b00 = low (value 0), 2'b01 = high (value 1), and 2'b10 or 2'b11 = floating (value 2). The index is 3*value(`sel_hi_i`) + value(`sel_lo_i`). The address is the index for indices 0 to 7; index 8 (both floating) aliases to 3'b000.
- R3: Changes on the selection inputs have no effect on `latched_addr` or on address matching unless a reset or a recognised general-call command occurs.
- R4: Address bits are sampled MSB first on rising SCL edges. Bits 7:1 are the 7-bit address and bit 0 is the direction (1 = read). After the eighth bit, `addr_match` goes to 1 exactly when bits 7:1 equal {DEV_CODE (default 4'b1101), `latched_addr`}, and `rw_dir` takes bit 0.
- R5: For an accepted byte, `sda_pull_o` rises after the SCL falling edge that ends the eighth bit. It falls after the SCL falling edge that ends the ninth clock. It is never high during the eighth bit.
- R6: A byte that is not accepted gets no acknowledge. The rest of that transaction is ignored, including any later byte equal to the device address.
- R7: Address byte 0x00 (general call, write) is acknowledged and leaves `addr_match` at 0.
- R8: After a general call, command byte 0x06 is acknowledged and gives one `gc_reset_pulse` of one clock. `latched_addr` is then reloaded from the selection inputs.
- R9: After a general call, command byte 0x04 is acknowledged and gives one `gc_latch_pulse` with the same reload. No reset pulse is produced.
- R10: Any other command byte after a general call gets no acknowledge, no pulse and no reload.
- R11: Address byte 0x01 (general call with read) is not acknowledged.
- R12: A START, including a repeated START, clears `addr_match` and `rw_dir` and begins a new address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sel_hi_i | input | 2 | Three-level code of the upper selection input |
| sel_lo_i | input | 2 | Three-level code of the lower selection input |
| sda_pull_o | output | 1 | 1 = pull SDA low (acknowledge) |
| addr_match | output | 1 | Last address byte matched the device address |
| rw_dir | output | 1 | Direction bit of the last address byte |
| gc_reset_pulse | output | 1 | One-clock pulse on a general-call reset command |
| gc_latch_pulse | output | 1 | One-clock pulse on a general-call latch command |
| latched_addr | output | 3 | Currently held address bits A2..A0 |

## Verification
The bench moves the selection inputs without any latch event and confirms that the old address is still the one answered. A design that tracked the pins live would start answering the new address. The bench also sends general calls with command 0x06, 0x04, an unknown command and the read bit. This catches a design that reloads on the wrong command, confuses the two pulses, or acknowledges a general-call read. Further cases cover the both-floating alias, a device address sent after a rejected byte in the same transaction, and a repeated START after a match. These expose a decoder that misses the aliased index, a matcher that keeps listening after a mismatch, and a stale match flag.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

   typedef enum logic [1:0] {
      SEL_LOW   = 2'b00,
      SEL_HIGH  = 2'b01,
      SEL_FLOAT = 2'b10
   } sel_lvl_e;

   typedef enum logic [2:0] {
      FR_IDLE,
      FR_ADDR,
      FR_ACK_WAIT,
      FR_ACK_DRIVE,
      FR_CMD,
      FR_SKIP
   } frame_e;

   // Three-level code to value 0/1/2; the unused code reads as floating.
   function automatic logic [1:0] lvl_value(input logic [1:0] code);
      case (code)
         SEL_LOW:  return 2'd0;
         SEL_HIGH: return 2'd1;
         default:  return 2'd2;
      endcase
   endfunction

   // Pair of three-level codes to a 3-bit address; index 8 aliases to 0.
   function automatic logic [2:0] sel_to_addr(input logic [1:0] hi, input logic [1:0] lo);
      logic [3:0] idx;
      idx = ({2'b00, lvl_value(hi)} * 4'd3) + {2'b00, lvl_value(lo)};
      return (idx > 4'd7) ? 3'd0 : idx[2:0];
   endfunction

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
   parameter int   STAGES  = 2,
   parameter int   W       = 1,
   parameter logic RST_VAL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stage_q [STAGES];

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= {W{RST_VAL}};
            else        stage_q[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[k] <= {W{RST_VAL}};
            else        stage_q[k] <= stage_q[k-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/i2cm_sel_latch.sv
module i2cm_sel_latch
   import i2cm_pkg::*;
#(
   parameter int SEL_SYNC_STAGES = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sel_hi,
   input  logic [1:0] sel_lo,
   input  logic       relatch,
   output logic [2:0] pin_snap,
   output logic [2:0] held_addr
);

   localparam int CW = $clog2(SEL_SYNC_STAGES + 1) + 1;

   logic [3:0]    sel_q;
   logic [CW-1:0] fill_cnt;
   logic          boot_done;

   i2cm_sync #(.STAGES(SEL_SYNC_STAGES), .W(4), .RST_VAL(1'b0)) u_sel_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({sel_hi, sel_lo}),
      .q    (sel_q)
   );

   assign pin_snap = sel_to_addr(sel_q[3:2], sel_q[1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_cnt  <= '0;
         boot_done <= 1'b0;
         held_addr <= 3'd0;
      end else if (!boot_done) begin
         if (fill_cnt == CW'(SEL_SYNC_STAGES)) begin
            held_addr <= pin_snap;
            boot_done <= 1'b1;
         end else begin
            fill_cnt <= fill_cnt + 1'b1;
         end
      end else if (relatch) begin
         held_addr <= pin_snap;
      end
   end

endmodule

// File: rtl/i2cm_frame.sv
module i2cm_frame
   import i2cm_pkg::*;
#(
   parameter logic [3:0] DEV_CODE     = 4'b1101,
   parameter logic [7:0] GC_RESET_CMD = 8'h06,
   parameter logic [7:0] GC_LATCH_CMD = 8'h04
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_s,
   input  logic       sda_s,
   input  logic [2:0] held_addr,
   output logic       sda_pull,
   output logic       match_o,
   output logic       rw_o,
   output logic       reset_pulse,
   output logic       latch_pulse,
   output logic       gc_frame
);

   localparam logic [7:0] GC_ADDR_BYTE = 8'h00;

   frame_e     state;
   logic       scl_q, sda_q;
   logic [6:0] shreg;
   logic [2:0] bit_cnt;
   logic       cmd_phase;
   logic       scl_rise, scl_fall, start_c, stop_c;
   logic [7:0] nxt_byte;
   logic       own_hit, gc_hit, cmd_rst, cmd_lat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   always_comb begin
      scl_rise = scl_s & ~scl_q;
      scl_fall = ~scl_s & scl_q;
      start_c  = scl_s & scl_q & sda_q & ~sda_s;
      stop_c   = scl_s & scl_q & ~sda_q & sda_s;
      nxt_byte = {shreg, sda_s};
      own_hit  = (nxt_byte[7:1] == {DEV_CODE, held_addr});
      gc_hit   = (nxt_byte == GC_ADDR_BYTE);
      cmd_rst  = (nxt_byte == GC_RESET_CMD);
      cmd_lat  = (nxt_byte == GC_LATCH_CMD);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= FR_IDLE;
         shreg       <= '0;
         bit_cnt     <= '0;
         cmd_phase   <= 1'b0;
         gc_frame    <= 1'b0;
         sda_pull    <= 1'b0;
         match_o     <= 1'b0;
         rw_o        <= 1'b0;
         reset_pulse <= 1'b0;
         latch_pulse <= 1'b0;
      end else begin
         reset_pulse <= 1'b0;
         latch_pulse <= 1'b0;
         if (start_c) begin
            state     <= FR_ADDR;
            bit_cnt   <= '0;
            cmd_phase <= 1'b0;
            gc_frame  <= 1'b0;
            sda_pull  <= 1'b0;
            match_o   <= 1'b0;
            rw_o      <= 1'b0;
         end else if (stop_c) begin
            state    <= FR_IDLE;
            sda_pull <= 1'b0;
         end else begin
            case (state)
               FR_ADDR, FR_CMD: begin
                  if (scl_rise) begin
                     shreg   <= nxt_byte[6:0];
                     bit_cnt <= bit_cnt + 3'd1;
                     if (bit_cnt == 3'd7) begin
                        if (state == FR_ADDR) begin
                           match_o  <= own_hit;
                           rw_o     <= nxt_byte[0];
                           gc_frame <= gc_hit;
                           state    <= (own_hit || gc_hit) ? FR_ACK_WAIT : FR_SKIP;
                        end else begin
                           reset_pulse <= cmd_rst;
                           latch_pulse <= cmd_lat;
                           state       <= (cmd_rst || cmd_lat) ? FR_ACK_WAIT : FR_SKIP;
                        end
                     end
                  end
               end
               FR_ACK_WAIT: begin
                  if (scl_fall) begin
                     sda_pull <= 1'b1;
                     state    <= FR_ACK_DRIVE;
                  end
               end
               FR_ACK_DRIVE: begin
                  if (scl_fall) begin
                     sda_pull <= 1'b0;
                     bit_cnt  <= '0;
                     if (gc_frame && !cmd_phase) begin
                        cmd_phase <= 1'b1;
                        state     <= FR_CMD;
                     end else begin
                        state <= FR_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/i2c_addr_latch_match.sv
module i2c_addr_latch_match #(
   parameter logic [3:0] DEV_CODE        = 4'b1101,
   parameter int         BUS_SYNC_STAGES = 2,
   parameter int         SEL_SYNC_STAGES = 1,
   parameter logic [7:0] GC_RESET_CMD    = 8'h06,
   parameter logic [7:0] GC_LATCH_CMD    = 8'h04
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [1:0] sel_hi_i,
   input  logic [1:0] sel_lo_i,
   output logic       sda_pull_o,
   output logic       addr_match,
   output logic       rw_dir,
   output logic       gc_reset_pulse,
   output logic       gc_latch_pulse,
   output logic [2:0] latched_addr
);

   if (BUS_SYNC_STAGES < 2) begin : g_bad_bus_sync
      $error("BUS_SYNC_STAGES must be at least 2");
   end
   if (SEL_SYNC_STAGES < 1) begin : g_bad_sel_sync
      $error("SEL_SYNC_STAGES must be at least 1");
   end
   if (GC_RESET_CMD == GC_LATCH_CMD) begin : g_bad_cmds
      $error("general-call command codes must differ");
   end

   logic [1:0] bus_s;
   logic [2:0] pin_snap;
   logic       gc_frame;
   logic       relatch;

   i2cm_sync #(.STAGES(BUS_SYNC_STAGES), .W(2), .RST_VAL(1'b1)) u_bus_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({scl_i, sda_i}),
      .q    (bus_s)
   );

   assign relatch = gc_reset_pulse | gc_latch_pulse;

   i2cm_sel_latch #(.SEL_SYNC_STAGES(SEL_SYNC_STAGES)) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_hi   (sel_hi_i),
      .sel_lo   (sel_lo_i),
      .relatch  (relatch),
      .pin_snap (pin_snap),
      .held_addr(latched_addr)
   );

   i2cm_frame #(
      .DEV_CODE    (DEV_CODE),
      .GC_RESET_CMD(GC_RESET_CMD),
      .GC_LATCH_CMD(GC_LATCH_CMD)
   ) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_s      (bus_s[1]),
      .sda_s      (bus_s[0]),
      .held_addr  (latched_addr),
      .sda_pull   (sda_pull_o),
      .match_o    (addr_match),
      .rw_o       (rw_dir),
      .reset_pulse(gc_reset_pulse),
      .latch_pulse(gc_latch_pulse),
      .gc_frame   (gc_frame)
   );

endmodule

// File: rtl/i2c_addr_latch_match_chk.sv
module i2c_addr_latch_match_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sda_pull_o,
   input logic       addr_match,
   input logic       gc_frame,
   input logic       gc_reset_pulse,
   input logic       gc_latch_pulse,
   input logic [2:0] latched_addr,
   input logic [2:0] pin_snap
);

   logic [1:0] cyc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cyc <= 2'd0;
      else if (cyc != 2'd3)    cyc <= cyc + 2'd1;
   end

   // R3: held address moves only in the cycle after a command pulse
   p_hold_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd3 && !$past(gc_reset_pulse) && !$past(gc_latch_pulse)) |-> $stable(latched_addr));

   // R8: a command pulse reloads the held address from the pins
   p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd3 && ($past(gc_reset_pulse) || $past(gc_latch_pulse)))
         |-> (latched_addr == $past(pin_snap)));

   // R8: reset pulse lasts one clock
   p_pulse_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
      gc_reset_pulse |=> !gc_reset_pulse);

   // R9: the two command pulses never coincide
   p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(gc_reset_pulse && gc_latch_pulse));

   // R10: pulses only inside a general-call frame
   p_pulse_in_gc_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (gc_reset_pulse || gc_latch_pulse) |-> gc_frame);

   // R5: acknowledge outside a general call requires an own-address match
   p_ack_own_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_pull_o && !gc_frame) |-> addr_match);

endmodule

bind i2c_addr_latch_match i2c_addr_latch_match_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .sda_pull_o    (sda_pull_o),
   .addr_match    (addr_match),
   .gc_frame      (gc_frame),
   .gc_reset_pulse(gc_reset_pulse),
   .gc_latch_pulse(gc_latch_pulse),
   .latched_addr  (latched_addr),
   .pin_snap      (pin_snap)
);

// File: tb/i2c_addr_latch_match_test.sv
module i2c_addr_latch_match_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic [1:0] sel_hi = 2'b00;
   logic [1:0] sel_lo = 2'b00;
   logic       sda_pull_o, addr_match, rw_dir, gc_reset_pulse, gc_latch_pulse;
   logic [2:0] latched_addr;
   logic       sda_line;

   int errors = 0;
   int checks = 0;
   int rst_pulses = 0;
   int lat_pulses = 0;
   logic early_pull, late_pull;
   logic done = 1'b0;

   always #5 clk = ~clk;

   assign sda_line = m_sda & ~sda_pull_o;

   i2c_addr_latch_match uut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
      .sel_hi_i(sel_hi), .sel_lo_i(sel_lo),
      .sda_pull_o(sda_pull_o), .addr_match(addr_match), .rw_dir(rw_dir),
      .gc_reset_pulse(gc_reset_pulse), .gc_latch_pulse(gc_latch_pulse),
      .latched_addr(latched_addr)
   );

   always @(negedge clk) begin
      if (gc_reset_pulse) rst_pulses++;
      if (gc_latch_pulse) lat_pulses++;
   end

   // sel code, sel code, byte, ack, match, rw
   localparam logic [14:0] VEC [10] = '{
      {2'b00, 2'b00, 8'hD0, 3'b110},
      {2'b00, 2'b01, 8'hD3, 3'b111},
      {2'b00, 2'b10, 8'hD4, 3'b110},
      {2'b01, 2'b00, 8'hD7, 3'b111},
      {2'b01, 2'b01, 8'hD8, 3'b110},
      {2'b10, 2'b10, 8'hD0, 3'b110},
      {2'b10, 2'b01, 8'hDF, 3'b111},
      {2'b01, 2'b10, 8'hDC, 3'b000},
      {2'b10, 2'b00, 8'h5C, 3'b000},
      {2'b11, 2'b00, 8'hDC, 3'b110}
   };

   function automatic int lvl(input logic [1:0] c);
      if (c == 2'b00) return 0;
      if (c == 2'b01) return 1;
      return 2;
   endfunction

   function automatic logic [2:0] exp_addr(input logic [1:0] h, input logic [1:0] l);
      int n;
      n = lvl(h) * 3 + lvl(l);
      if (n == 8) return 3'd0;
      return 3'(n);
   endfunction

   task automatic check(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic q();
      repeat (5) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; q();
      m_scl = 1'b1; q();
      m_sda = 1'b0; q();
      m_scl = 1'b0; q();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; q();
      m_scl = 1'b1; q();
      m_sda = 1'b1; q();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; q();
         m_scl = 1'b1; q();
         if (i == 0) early_pull = sda_pull_o;
         q();
         m_scl = 1'b0; q();
      end
      m_sda = 1'b1; q();
      m_scl = 1'b1; q();
      ack = ~sda_line;
      q();
      m_scl = 1'b0; q();
      late_pull = sda_pull_o;
   endtask

   task automatic gc_cmd(input logic [7:0] cmd, output logic a1, output logic a2);
      bus_start();
      send_byte(8'h00, a1);
      send_byte(cmd, a2);
      bus_stop();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic ack, a1, a2;
      int rp, lp;
      logic [2:0] ea;

      // R1: outputs quiet under reset
      repeat (3) @(negedge clk);
      check(!sda_pull_o && !addr_match && !rw_dir && !gc_reset_pulse && !gc_latch_pulse,
            "R1 reset outputs", {sda_pull_o, addr_match, rw_dir}, 0);

      // Table walk: R2 decode, R4 match/direction, R6 mismatch
      for (int v = 0; v < 10; v++) begin
         sel_hi = VEC[v][14:13];
         sel_lo = VEC[v][12:11];
         do_reset();
         ea = exp_addr(sel_hi, sel_lo);
         check(latched_addr == ea, "R2 decode after power-up R1", latched_addr, ea);
         bus_start();
         send_byte(VEC[v][10:3], ack);
         check(ack == VEC[v][2], "R4/R6 acknowledge", ack, VEC[v][2]);
         check(addr_match == VEC[v][1], "R4 addr_match", addr_match, VEC[v][1]);
         if (VEC[v][1]) check(rw_dir == VEC[v][0], "R4 rw_dir", rw_dir, VEC[v][0]);
         if (VEC[v][2]) begin
            check(!early_pull, "R5 no pull during eighth bit", early_pull, 0);
            check(!late_pull, "R5 pull released after ninth clock", late_pull, 0);
         end
         bus_stop();
      end

      // R3: pins move, no latch event -> held address unchanged (last latched 6)
      sel_hi = 2'b00; sel_lo = 2'b00;
      repeat (20) @(negedge clk);
      check(latched_addr == 3'd6, "R3 held address kept", latched_addr, 6);
      bus_start(); send_byte(8'hDC, ack); bus_stop();
      check(ack == 1'b1, "R3 old address still answered", ack, 1);
      bus_start(); send_byte(8'hD0, ack); bus_stop();
      check(ack == 1'b0, "R3 new pin address ignored", ack, 0);

      // R7, R8: general-call reset
      rp = rst_pulses; lp = lat_pulses;
      bus_start();
      send_byte(8'h00, a1);
      check(a1 == 1'b1, "R7 general call acknowledged", a1, 1);
      check(addr_match == 1'b0, "R7 addr_match stays low", addr_match, 0);
      send_byte(8'h06, a2);
      bus_stop();
      repeat (4) @(negedge clk);
      check(a2 == 1'b1, "R8 reset command acknowledged", a2, 1);
      check(rst_pulses == rp + 1, "R8 one reset pulse", rst_pulses - rp, 1);
      check(lat_pulses == lp, "R8 no latch pulse", lat_pulses - lp, 0);
      check(latched_addr == 3'd0, "R8 address reloaded", latched_addr, 0);

      // R9: general-call latch
      sel_hi = 2'b01; sel_lo = 2'b01;
      repeat (4) @(negedge clk);
      rp = rst_pulses; lp = lat_pulses;
      gc_cmd(8'h04, a1, a2);
      check(a2 == 1'b1, "R9 latch command acknowledged", a2, 1);
      check(lat_pulses == lp + 1, "R9 one latch pulse", lat_pulses - lp, 1);
      check(rst_pulses == rp, "R9 no reset pulse", rst_pulses - rp, 0);
      check(latched_addr == 3'd4, "R9 address reloaded", latched_addr, 4);

      // R10: unknown command
      sel_hi = 2'b00; sel_lo = 2'b01;
      repeat (4) @(negedge clk);
      rp = rst_pulses; lp = lat_pulses;
      gc_cmd(8'h05, a1, a2);
      check(a2 == 1'b0, "R10 unknown command not acknowledged", a2, 0);
      check(rst_pulses == rp && lat_pulses == lp, "R10 no pulse",
            (rst_pulses - rp) + (lat_pulses - lp), 0);
      check(latched_addr == 3'd4, "R10 no reload", latched_addr, 4);

      // R11: general call with read bit
      bus_start(); send_byte(8'h01, ack); bus_stop();
      check(ack == 1'b0, "R11 general-call read rejected", ack, 0);
      check(latched_addr == 3'd4, "R11 no reload", latched_addr, 4);

      // R6: after a rejected byte the device address is ignored
      bus_start();
      send_byte(8'h50, ack);
      check(ack == 1'b0, "R6 foreign address rejected", ack, 0);
      send_byte(8'hD8, ack);
      check(ack == 1'b0, "R6 rest of transaction ignored", ack, 0);
      check(addr_match == 1'b0, "R6 addr_match low", addr_match, 0);
      bus_stop();

      // R12: repeated START clears the match
      bus_start();
      send_byte(8'hD9, ack);
      check(ack == 1'b1 && addr_match && rw_dir, "R12 match before restart",
            {ack, addr_match, rw_dir}, 7);
      bus_start();
      check(addr_match == 1'b0 && rw_dir == 1'b0, "R12 cleared by repeated START",
            {addr_match, rw_dir}, 0);
      send_byte(8'h50, ack);
      check(ack == 1'b0, "R12 new byte evaluated", ack, 0);
      bus_stop();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule